// File: doc/BRIEF.md
# Ripple-Carry Four-Function ALU

This block is a purely combinational arithmetic and logic unit. It is a chain of identical one-bit slices. Two operands and a two-bit function code go in. A result of the same width and a single carry-out come out. Addition and subtraction share one ripple carry path. Subtraction feeds the slices the complement of the second operand and injects a carry of one into the lowest slice. That carry comes directly from the low bit of the function code. Bitwise OR and AND use the same slices: each slice picks its logic result and holds its own carry-out at zero.

The block has no clock, state or reset. A surrounding datapath places it between registers and gives the carry chain a full cycle to settle. With the default width of eight, only the carry of the top slice leaves the block.

Top module: `bitslice_alu`

## Requirements
- R1: With fsel = 2'b00 (add), {carry_out, result} equals the 9-bit unsigned sum opa + opb.
- R2: With fsel = 2'b01 (subtract), {carry_out, result} equals opa + ~opb + 1 taken to 9 bits, so carry_out is 1 exactly when opa >= opb unsigned.
- R3: With fsel = 2'b10 (OR), result equals opa | opb, using the uninverted opb.
- R4: With fsel = 2'b11 (AND), result equals opa & opb, using the uninverted opb.
- R5: Whenever fsel[1] is 1 (OR or AND), carry_out is 0 for every operand pair, including all-ones operands.
- R6: Subtracting all ones from all ones gives result 8'h00 with carry_out 1.
- R7: Adding all ones to all ones gives result 8'hFE (bit 0 clear) with carry_out 1, the carry having passed every higher slice.
- R8: A carry entering at bit 0 travels the full chain: 8'hFF + 8'h01 gives result 8'h00 with carry_out 1, and subtracting 8'h00 from 8'h00 gives 8'h00 with carry_out 1.
- R9: Outputs depend only on the present inputs. A change of any input appears at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand; complemented inside the slices only for subtract |
| fsel | input | 2 | Function code: 00 add, 01 subtract, 10 OR, 11 AND |
| result | output | 8 | Result of the selected function |
| carry_out | output | 1 | Carry out of the top slice; 0 for logic functions |

## Verification
A carry can ripple and be suppressed at the same time. In an OR or AND, each slice's adder still forms a carry from its operands. Only the per-slice gate keeps that carry from reaching the next slice and the output. The bench provokes this with operand pairs that would give a full-length carry under addition, such as all ones with all ones and all ones with one. It applies those pairs under both logic codes and also under add. It judges that carry_out is exactly 0 and the result is the pure bitwise value in the logic cases, and that the carry arrives under add.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        FN_ADD = 2'b00,
        FN_SUB = 2'b01,
        FN_OR  = 2'b10,
        FN_AND = 2'b11
    } alu_fn_e;

endpackage

// File: rtl/alu_full_adder.sv
module alu_full_adder (
    input  logic x_in,
    input  logic y_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);
    logic half_x;

    always_comb begin
        half_x = x_in ^ y_in;
        s_out  = half_x ^ c_in;
        c_out  = (x_in & y_in) | (half_x & c_in);
    end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic    a_bit,
    input  logic    b_bit,
    input  logic    c_in,
    input  alu_fn_e fn,
    output logic    y_bit,
    output logic    c_out
);
    logic b_cond;
    logic sum_bit;
    logic raw_carry;

    // complement the second operand only when subtracting
    always_comb begin
        b_cond = b_bit ^ (fn == FN_SUB);
    end

    alu_full_adder u_fa (
        .x_in  (a_bit),
        .y_in  (b_cond),
        .c_in  (c_in),
        .s_out (sum_bit),
        .c_out (raw_carry)
    );

    // result select and carry gate
    always_comb begin
        unique case (fn)
            FN_ADD, FN_SUB: begin
                y_bit = sum_bit;
                c_out = raw_carry;
            end
            FN_OR: begin
                y_bit = a_bit | b_bit;
                c_out = 1'b0;
            end
            FN_AND: begin
                y_bit = a_bit & b_bit;
                c_out = 1'b0;
            end
            default: begin
                y_bit = 1'b0;
                c_out = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [1:0]       fsel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    localparam int CHAIN = WIDTH + 1;

    alu_fn_e          fn;
    logic [CHAIN-1:0] chain;

    always_comb begin
        fn       = alu_fn_e'(fsel);
        // low code bit seeds the chain: 1 for subtract, 0 for add
        chain[0] = fsel[0];
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_slice u_slice (
            .a_bit (opa[i]),
            .b_bit (opb[i]),
            .c_in  (chain[i]),
            .fn    (fn),
            .y_bit (result[i]),
            .c_out (chain[i+1])
        );
    end

    always_comb begin
        carry_out = chain[WIDTH];
    end
endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [1:0]       fsel,
    input logic [WIDTH-1:0] result,
    input logic             carry_out
);
    localparam logic [WIDTH:0] ONE = {{WIDTH{1'b0}}, 1'b1};

    logic [WIDTH:0] wide_a;
    logic [WIDTH:0] wide_b;
    logic [WIDTH:0] wide_nb;

    always_comb begin
        wide_a  = {1'b0, opa};
        wide_b  = {1'b0, opb};
        wide_nb = {1'b0, ~opb};
        if (fsel == 2'b00)
            assert_add_sum_R1: assert ({carry_out, result} == wide_a + wide_b)
                else $error("R1 add mismatch");
        if (fsel == 2'b01)
            assert_sub_sum_R2: assert ({carry_out, result} == wide_a + wide_nb + ONE)
                else $error("R2 subtract mismatch");
        if (fsel == 2'b10)
            assert_or_bits_R3: assert (result == (opa | opb))
                else $error("R3 OR mismatch");
        if (fsel == 2'b11)
            assert_and_bits_R4: assert (result == (opa & opb))
                else $error("R4 AND mismatch");
        if (fsel[1])
            assert_logic_no_carry_R5: assert (carry_out == 1'b0)
                else $error("R5 carry not held low");
    end
endmodule

bind bitslice_alu bitslice_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .opa       (opa),
    .opb       (opb),
    .fsel      (fsel),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/sim_bitslice_alu.sv
`timescale 1ns/1ps
module sim_bitslice_alu;
    localparam int NVEC = 14;

    logic       clk = 1'b0;
    logic [7:0] opa;
    logic [7:0] opb;
    logic [1:0] fsel;
    logic [7:0] result;
    logic       carry_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bitslice_alu #(.WIDTH(8)) u0 (
        .opa       (opa),
        .opb       (opb),
        .fsel      (fsel),
        .result    (result),
        .carry_out (carry_out)
    );

    // {fsel, opa, opb, expected result, expected carry}
    localparam logic [26:0] VEC [NVEC] = '{
        {2'b00, 8'h00, 8'h00, 8'h00, 1'b0},  // R1
        {2'b00, 8'h0F, 8'h01, 8'h10, 1'b0},  // R1
        {2'b00, 8'hFF, 8'hFF, 8'hFE, 1'b1},  // R7
        {2'b00, 8'hFF, 8'h01, 8'h00, 1'b1},  // R8
        {2'b01, 8'hFF, 8'hFF, 8'h00, 1'b1},  // R6
        {2'b01, 8'h05, 8'h03, 8'h02, 1'b1},  // R2
        {2'b01, 8'h03, 8'h05, 8'hFE, 1'b0},  // R2
        {2'b01, 8'h00, 8'h00, 8'h00, 1'b1},  // R8
        {2'b10, 8'hF0, 8'h0F, 8'hFF, 1'b0},  // R3
        {2'b10, 8'hFF, 8'hFF, 8'hFF, 1'b0},  // R5
        {2'b10, 8'hFF, 8'h01, 8'hFF, 1'b0},  // R5
        {2'b11, 8'hAA, 8'h0F, 8'h0A, 1'b0},  // R4
        {2'b11, 8'hFF, 8'hFF, 8'hFF, 1'b0},  // R5
        {2'b11, 8'hFF, 8'h01, 8'h01, 1'b0}   // R5
    };

    task automatic check(input string tag, input logic [7:0] exp_r, input logic exp_c);
        checks++;
        if (result !== exp_r || carry_out !== exp_c) begin
            errors++;
            $display("FAIL %s fsel=%b a=%h b=%h: got %h/%b expected %h/%b",
                     tag, fsel, opa, opb, result, carry_out, exp_r, exp_c);
        end
    endtask

    function automatic logic [8:0] model(input logic [1:0] f, input logic [7:0] a, input logic [7:0] b);
        case (f)
            2'b00:   return {1'b0, a} + {1'b0, b};
            2'b01:   return {1'b0, a} + {1'b0, ~b} + 9'd1;
            2'b10:   return {1'b0, a | b};
            default: return {1'b0, a & b};
        endcase
    endfunction

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] m;
        // initial state: zero inputs under add (R1)
        opa = 8'h00; opb = 8'h00; fsel = 2'b00;
        @(negedge clk);
        check("R1 zero inputs", 8'h00, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            @(posedge clk);
            {fsel, opa, opb} = VEC[i][26:9];
            @(negedge clk);
            check("R1-R8 table", VEC[i][8:1], VEC[i][0]);
        end

        // combinational: outputs follow inputs with no edge (R9)
        @(posedge clk);
        #1 fsel = 2'b00; opa = 8'h10; opb = 8'h20;
        #1 check("R9 no clock", 8'h30, 1'b0);
        #1 opb = 8'hF0;
        #1 check("R9 no clock", 8'h00, 1'b1);
        #1 fsel = 2'b11;
        #1 check("R9 no clock R5", 8'h10, 1'b0);

        // random operands against reference model (R1 R2 R3 R4 R5)
        for (int i = 0; i < 400; i++) begin
            @(posedge clk);
            fsel = 2'($urandom);
            opa  = 8'($urandom);
            opb  = 8'($urandom);
            m    = model(fsel, opa, opb);
            @(negedge clk);
            check("R1/R2/R3/R4/R5 random", m[7:0], m[8]);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule